// File: doc/BRIEF.md
# Banked Font Address Generator

This block forms the read address into a 32 KB glyph store that holds sixteen 2 KB character images, called slots. Each character on screen carries its own attribute byte. Two bits of that byte pick one of four slots inside a group. A 2-bit group value from a control register picks which group of four slots is active. Four different fonts can therefore share the screen at once. A 4 KB font is stored in two neighbouring slots, and the attribute bits then choose between its two halves.

A fetch is presented on one cycle: the character code, the pixel row within the cell, the attribute byte, the current group value and a flag that marks the first row of a new character. The address appears combinationally on the same cycle. The glyph store is synchronous, so the row byte comes back on the next cycle. The block returns that byte with a valid flag and holds it until the next return. The group value is captured only when a new character starts, so a register write that lands partway through a character does not change that character's font.

Top module: `glyph_fetch`

## Requirements
- R1: While `req_i` is high, `rom_addr_o[10:0]` equals `{code_i, row_i}`, and `rom_addr_o[14:11]` is the slot index.
- R2: Slot index = group*4 + attr_i[7]*2 + attr_i[3]. Attribute bit 7 is the more significant bit, so group 0 with bit 7 = 0 and bit 3 = 1 gives slot 1. The group occupies `rom_addr_o[14:13]`.
- R3: Attribute bits 0, 1, 2, 4, 5 and 6 have no effect on the address.
- R4: The group is taken from `grp_i` on a fetch with `start_i` high. Fetches with `start_i` low use the group captured at the last start, whatever `grp_i` holds. After reset the captured group is 0.
- R5: While reset is asserted, `glyph_vld_o` is 0 and `glyph_o` is 0.
- R6: `glyph_vld_o` is high exactly one cycle after a cycle with `req_i` high. In that cycle `glyph_o` equals `rom_data_i`.
- R7: In a cycle where `glyph_vld_o` is low, `glyph_o` keeps the last returned byte.
- R8: `rom_en_o` equals `req_i`.
- R9: For a 4 KB font in slots 2g and 2g+1 (attr bit 7 fixed), toggling attr bit 3 moves the address by exactly 2048, with code and row unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Fetch request this cycle |
| start_i | input | 1 | Fetch is the first row of a new character |
| code_i | input | 8 | Character code |
| row_i | input | 3 | Pixel row within the cell |
| attr_i | input | 8 | Attribute byte of the character |
| grp_i | input | 2 | Group value from the control register |
| rom_addr_o | output | 15 | Glyph store address |
| rom_en_o | output | 1 | Glyph store read enable |
| rom_data_i | input | 8 | Glyph store read data, one cycle after the address |
| glyph_o | output | 8 | Returned glyph row byte |
| glyph_vld_o | output | 1 | Returned byte is new this cycle |

## Verification
The bench builds the block with its default widths: an 8-bit code, a 3-bit row, a 2-bit group and an 8-bit data path, which gives the full 15-bit, sixteen-slot address space. With these widths every slot, each group boundary and both halves of a 4 KB font can be reached by direct stimulus. A group change in the middle of a character's rows can also be placed at any row. The glyph store model returns a byte computed from the address, so a wrong slot shows up as wrong data as well as a wrong address.

// File: rtl/glyph_pkg.sv
package glyph_pkg;
  localparam int unsigned CODE_W_DEF  = 8;
  localparam int unsigned ROW_W_DEF   = 3;
  localparam int unsigned GRP_W_DEF   = 2;
  localparam int unsigned ATTR_W_DEF  = 8;
  localparam int unsigned DATA_W_DEF  = 8;
  localparam int unsigned SEL_HI_DEF  = 7;
  localparam int unsigned SEL_LO_DEF  = 3;
  localparam int unsigned SUB_W       = 2;
endpackage

// File: rtl/glyph_group_hold.sv
module glyph_group_hold #(
  parameter int unsigned GRP_W = glyph_pkg::GRP_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             start_i,
  input  logic [GRP_W-1:0] grp_i,
  output logic [GRP_W-1:0] grp_o
);
  logic [GRP_W-1:0] grp_q;
  logic             take;

  assign take = req_i & start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   grp_q <= '0;
    else if (take) grp_q <= grp_i;
  end

  // new character uses the live value, later rows the captured one
  assign grp_o = take ? grp_i : grp_q;
endmodule

// File: rtl/glyph_addr_pack.sv
module glyph_addr_pack #(
  parameter int unsigned CODE_W = glyph_pkg::CODE_W_DEF,
  parameter int unsigned ROW_W  = glyph_pkg::ROW_W_DEF,
  parameter int unsigned GRP_W  = glyph_pkg::GRP_W_DEF,
  parameter int unsigned ATTR_W = glyph_pkg::ATTR_W_DEF,
  parameter int unsigned SEL_HI = glyph_pkg::SEL_HI_DEF,
  parameter int unsigned SEL_LO = glyph_pkg::SEL_LO_DEF,
  localparam int unsigned SUB_W = glyph_pkg::SUB_W,
  localparam int unsigned ADDR_W = GRP_W + SUB_W + CODE_W + ROW_W
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [ATTR_W-1:0] attr_i,
  input  logic [GRP_W-1:0]  grp_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [SUB_W-1:0] sub;

  assign sub    = {attr_i[SEL_HI], attr_i[SEL_LO]};
  assign addr_o = {grp_i, sub, code_i, row_i};
endmodule

// File: rtl/glyph_row_return.sv
module glyph_row_return #(
  parameter int unsigned DATA_W = glyph_pkg::DATA_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [DATA_W-1:0] rom_data_i,
  output logic [DATA_W-1:0] glyph_o,
  output logic              glyph_vld_o
);
  logic              vld_q;
  logic [DATA_W-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      hold_q <= '0;
    end else begin
      vld_q  <= req_i;
      hold_q <= glyph_o;
    end
  end

  // store output is already registered; pass it on the return cycle
  assign glyph_o     = vld_q ? rom_data_i : hold_q;
  assign glyph_vld_o = vld_q;
endmodule

// File: rtl/glyph_fetch.sv
module glyph_fetch #(
  parameter int unsigned CODE_W = glyph_pkg::CODE_W_DEF,
  parameter int unsigned ROW_W  = glyph_pkg::ROW_W_DEF,
  parameter int unsigned GRP_W  = glyph_pkg::GRP_W_DEF,
  parameter int unsigned ATTR_W = glyph_pkg::ATTR_W_DEF,
  parameter int unsigned DATA_W = glyph_pkg::DATA_W_DEF,
  parameter int unsigned SEL_HI = glyph_pkg::SEL_HI_DEF,
  parameter int unsigned SEL_LO = glyph_pkg::SEL_LO_DEF,
  localparam int unsigned ADDR_W = GRP_W + glyph_pkg::SUB_W + CODE_W + ROW_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              start_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [ATTR_W-1:0] attr_i,
  input  logic [GRP_W-1:0]  grp_i,
  output logic [ADDR_W-1:0] rom_addr_o,
  output logic              rom_en_o,
  input  logic [DATA_W-1:0] rom_data_i,
  output logic [DATA_W-1:0] glyph_o,
  output logic              glyph_vld_o
);
  logic [GRP_W-1:0] grp_eff;

  glyph_group_hold #(.GRP_W(GRP_W)) u_grp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .start_i (start_i),
    .grp_i   (grp_i),
    .grp_o   (grp_eff)
  );

  glyph_addr_pack #(
    .CODE_W (CODE_W),
    .ROW_W  (ROW_W),
    .GRP_W  (GRP_W),
    .ATTR_W (ATTR_W),
    .SEL_HI (SEL_HI),
    .SEL_LO (SEL_LO)
  ) u_addr (
    .code_i (code_i),
    .row_i  (row_i),
    .attr_i (attr_i),
    .grp_i  (grp_eff),
    .addr_o (rom_addr_o)
  );

  glyph_row_return #(.DATA_W(DATA_W)) u_ret (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .rom_data_i  (rom_data_i),
    .glyph_o     (glyph_o),
    .glyph_vld_o (glyph_vld_o)
  );

  assign rom_en_o = req_i;
endmodule

// File: rtl/glyph_fetch_chk.sv
module glyph_fetch_chk #(
  parameter int unsigned CODE_W = 8,
  parameter int unsigned ROW_W  = 3,
  parameter int unsigned GRP_W  = 2,
  parameter int unsigned ATTR_W = 8,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 15
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              start_i,
  input logic [CODE_W-1:0] code_i,
  input logic [ROW_W-1:0]  row_i,
  input logic [ADDR_W-1:0] rom_addr_o,
  input logic              rom_en_o,
  input logic [DATA_W-1:0] rom_data_i,
  input logic [DATA_W-1:0] glyph_o,
  input logic              glyph_vld_o
);
  // R1
  low_field_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |-> rom_addr_o[CODE_W+ROW_W-1:0] == {code_i, row_i});

  // R4
  grp_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !start_i && $past(req_i)) |->
      rom_addr_o[ADDR_W-1 -: GRP_W] == $past(rom_addr_o[ADDR_W-1 -: GRP_W]));

  // R5
  always @(posedge clk_i)
    if (!rst_ni) rst_quiet_chk: assert (!glyph_vld_o && glyph_o == '0);

  // R6
  vld_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> glyph_vld_o);

  // R6
  vld_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !glyph_vld_o);

  // R6
  data_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    glyph_vld_o |-> glyph_o == rom_data_i);

  // R7
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !glyph_vld_o |-> $stable(glyph_o));

  // R8
  en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rom_en_o == req_i);
endmodule

bind glyph_fetch glyph_fetch_chk #(
  .CODE_W (CODE_W),
  .ROW_W  (ROW_W),
  .GRP_W  (GRP_W),
  .ATTR_W (ATTR_W),
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .start_i     (start_i),
  .code_i      (code_i),
  .row_i       (row_i),
  .rom_addr_o  (rom_addr_o),
  .rom_en_o    (rom_en_o),
  .rom_data_i  (rom_data_i),
  .glyph_o     (glyph_o),
  .glyph_vld_o (glyph_vld_o)
);

// File: tb/glyph_fetch_bench.sv
`timescale 1ns/1ps
module glyph_fetch_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, start_i = 1'b0;
  logic [7:0]  code_i = '0, attr_i = '0;
  logic [2:0]  row_i = '0;
  logic [1:0]  grp_i = '0;
  logic [14:0] rom_addr_o;
  logic        rom_en_o;
  logic [7:0]  rom_data_i = '0;
  logic [7:0]  glyph_o;
  logic        glyph_vld_o;

  int tests = 0, fails = 0;
  int m_grp = 0;
  int m_held = 0;
  int exp_vld = 0, exp_glyph = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  glyph_fetch u_glyph_fetch (
    .clk_i, .rst_ni, .req_i, .start_i, .code_i, .row_i, .attr_i, .grp_i,
    .rom_addr_o, .rom_en_o, .rom_data_i, .glyph_o, .glyph_vld_o
  );

  function automatic int font_byte(input int a);
    return ((a * 149) ^ (a >> 7) ^ (a >> 11) ^ 8'h5A) & 255;
  endfunction

  // synchronous glyph store model
  always @(posedge clk_i)
    if (rom_en_o) rom_data_i <= 8'(font_byte(int'(rom_addr_o)));

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, check address, then check return after edge
  task automatic cyc(input bit rq, input bit st, input int code, input int row,
                     input int attr, input int grp, input string tag);
    int a;
    @(negedge clk_i);
    req_i = rq; start_i = st; code_i = 8'(code); row_i = 3'(row);
    attr_i = 8'(attr); grp_i = 2'(grp);
    if (rq && st) m_grp = grp;
    #1;
    a = (m_grp * 4 + ((attr >> 7) & 1) * 2 + ((attr >> 3) & 1)) * 2048
        + (code & 255) * 8 + (row & 7);
    check({tag, " R8 en"}, int'(rom_en_o), int'(rq));
    if (rq) check({tag, " R1 R2 addr"}, int'(rom_addr_o), a);
    @(posedge clk_i); #1;
    check({tag, " R6 vld"}, int'(glyph_vld_o), int'(rq));
    if (rq) m_held = font_byte(a);
    check({tag, rq ? " R6 data" : " R7 hold"}, int'(glyph_o), m_held);
  endtask

  initial begin : wd
    repeat (50000) @(posedge clk_i);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int a0, a1, lf;
    #2;
    check("R5 vld in reset", int'(glyph_vld_o), 0);
    check("R5 glyph in reset", int'(glyph_o), 0);
    repeat (3) @(posedge clk_i);
    #1;
    check("R5 vld held reset", int'(glyph_vld_o), 0);
    @(negedge clk_i); rst_ni = 1'b1;

    // R4 reset group 0 with no start seen yet
    cyc(1, 0, 8'h41, 0, 8'h00, 3, "R4 rst grp");

    // R2 every slot, R1 several codes/rows
    for (int g = 0; g < 4; g++)
      for (int s = 0; s < 4; s++)
        cyc(1, 1, 16 * g + s + 8'h30, (g + s) & 7, ((s >> 1) << 7) | ((s & 1) << 3), g, "R2 slot");

    // R3 unused attribute bits
    cyc(1, 1, 8'h7E, 5, 8'h00, 2, "R3 base");
    a0 = int'(rom_addr_o);
    cyc(1, 1, 8'h7E, 5, 8'h77, 2, "R3 noise");
    check("R3 same addr", int'(rom_addr_o), a0);

    // R4 group change mid-character is deferred
    cyc(1, 1, 8'h12, 0, 8'h08, 1, "R4 start");
    for (int r = 1; r < 8; r++) cyc(1, 0, 8'h12, r, 8'h08, (r & 1) ? 3 : 0, "R4 rows");
    cyc(1, 1, 8'h13, 0, 8'h08, 3, "R4 next char");
    check("R4 new group field", int'(rom_addr_o[14:13]), 3);

    // R7 idle holds last byte
    for (int i = 0; i < 4; i++) cyc(0, 0, i, i, 8'hFF, i, "R7 idle");

    // R9 4 KB font banks
    cyc(1, 1, 8'hC4, 6, 8'h80, 1, "R9 bank0");
    a0 = int'(rom_addr_o);
    cyc(1, 1, 8'hC4, 6, 8'h88, 1, "R9 bank1");
    a1 = int'(rom_addr_o);
    check("R9 bank stride", a1 - a0, 2048);

    // mixed pattern with gaps
    lf = 32'h1ACE;
    for (int i = 0; i < 80; i++) begin
      lf = (lf << 1) ^ (((lf >> 15) ^ (lf >> 13)) & 1);
      cyc((lf & 3) != 0, ((lf >> 2) & 7) == 0, (lf >> 3) & 255, lf >> 11,
          (lf >> 5) & 255, (lf >> 9) & 3, "R1 R6 mix");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule